// File: doc/BRIEF.md
# Fixed On-Time Pulse-Frequency Controller

This block drives the two power switches of a buck converter at light load. It works on a sampling clock. On each rising edge it reads a one-bit comparator result that is high when the converter output is below its reference. If the output is low and no switching cycle is under way, the block turns the high-side switch on for a fixed number of clocks. It then leaves one clock with both switches off, and turns the low-side switch on for a fixed minimum off-time. After that it returns to idle and waits for the comparator again.

The on-time comes from a writable register. Its reset value is 0.8 of a nominal switching period, counted in clocks. A fixed on-time keeps the ripple free of the jitter that the coarse sampling of the comparator would otherwise add while the output rises.

The block switches only when it is enabled and the mode input selects pulse-frequency operation. When the mode input selects PWM, the block stays idle and the PWM loop elsewhere takes over.

Top module: `fot_pfm_ctrl`

## Requirements
- R1: After reset both gate commands are low and the on-time register holds TSW_CYCLES*4/5 clocks (16 with the defaults), so the first pulse is that long.
- R2: When idle, enabled and in PFM mode (`mode_pfm`=1), a sampled `cmp_low`=1 makes `pfet_on` rise after that edge and stay high for exactly the on-time register value in clocks.
- R3: While `cmp_low` is sampled 0 in idle, no high-side pulse starts and both outputs stay low.
- R4: `pfet_on` and `nfet_on` are never high together. Exactly one clock with both low separates the end of the high-side pulse from the start of the low-side interval.
- R5: The low-side interval lasts TOFF_CYCLES clocks (4 with the defaults). It is followed by at least one idle clock before the next pulse can start.
- R6: A `cmp_low`=1 sampled during the high-side pulse, the dead clock or the low-side interval has no effect: the running sequence is unchanged and no extra pulse is queued.
- R7: When `en`=0 or `mode_pfm`=0, both outputs are low in the same cycle and any running sequence is abandoned. The block restarts from idle when both inputs return high.
- R8: A `ton_wr`=1 at an edge loads `ton_wdata` into the on-time register, and a written value of 0 is stored as 1. A pulse already running keeps its length.
- R9: When a register write and a pulse start fall on the same edge, that pulse uses the value held before the write. The new value applies from the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Comparator sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Switching enable; 0 holds both switches off |
| mode_pfm | input | 1 | 1 selects PFM operation, 0 selects PWM (block idle) |
| cmp_low | input | 1 | Sampled comparator: 1 when the output is below the reference |
| ton_wr | input | 1 | Write strobe for the on-time register |
| ton_wdata | input | CNT_W | On-time value in clocks |
| pfet_on | output | 1 | High-side gate command |
| nfet_on | output | 1 | Low-side gate command |

## Verification
Two events can land on the same edge. A write to the on-time register can coincide with the comparator starting a pulse. An enable drop can also arrive in the middle of a high-side pulse. The bench provokes the first by raising `ton_wr` and `cmp_low` in the same cycle and judges it by the width of the pulse that follows, which must be the old value, and of the next one. It provokes the second by dropping `en` partway through a pulse and checks that both outputs fall at once and that no low-side interval follows. A behavioural model built on pulse age is compared with both outputs on every clock.

// File: rtl/fot_pfm_pkg.sv
package fot_pfm_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_DEAD = 2'd2,
        PH_LOW  = 2'd3
    } pfm_phase_e;

endpackage

// File: rtl/fot_ton_reg.sv
module fot_ton_reg #(
    parameter int CNT_W   = 8,
    parameter int TON_RST = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] ton_q
);
    localparam logic [CNT_W-1:0] RST_VAL = CNT_W'(TON_RST);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    logic [CNT_W-1:0] ton_d;

    always_comb begin
        ton_d = ton_q;
        if (wr) begin
            ton_d = (wdata == '0) ? ONE : wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ton_q <= RST_VAL;
        else        ton_q <= ton_d;
    end

    AST_TON_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ton_q != '0); // R8

    AST_TON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wdata != '0) |=> ton_q == $past(wdata)); // R8

endmodule

// File: rtl/fot_gate_out.sv
module fot_gate_out
    import fot_pfm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  pfm_phase_e phase,
    input  logic       allow,
    output logic       pfet_on,
    output logic       nfet_on
);
    always_comb begin
        pfet_on = allow && (phase == PH_HIGH);
        nfet_on = allow && (phase == PH_LOW);
    end

    AST_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !(pfet_on && nfet_on)); // R4

    AST_DEAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nfet_on) |-> !$past(pfet_on)); // R4

    AST_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !allow |-> (!pfet_on && !nfet_on)); // R7

endmodule

// File: rtl/fot_pfm_ctrl.sv
module fot_pfm_ctrl
    import fot_pfm_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int TSW_CYCLES  = 20,
    parameter int TOFF_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             mode_pfm,
    input  logic             cmp_low,
    input  logic             ton_wr,
    input  logic [CNT_W-1:0] ton_wdata,
    output logic             pfet_on,
    output logic             nfet_on
);
    localparam int               TON_DEFAULT = (TSW_CYCLES * 4) / 5;
    localparam logic [CNT_W-1:0] TOFF_LAST   = CNT_W'(TOFF_CYCLES - 1);
    localparam logic [CNT_W-1:0] ONE         = CNT_W'(1);

    typedef struct packed {
        pfm_phase_e       phase;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t             seq_d, seq_q;
    logic             allow;
    logic [CNT_W-1:0] ton_q;

    fot_ton_reg #(
        .CNT_W   (CNT_W),
        .TON_RST (TON_DEFAULT)
    ) u_ton (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (ton_wr),
        .wdata (ton_wdata),
        .ton_q (ton_q)
    );

    always_comb begin
        allow = en && mode_pfm;
        seq_d = seq_q;
        if (!allow) begin
            seq_d.phase = PH_IDLE;
            seq_d.cnt   = '0;
        end else begin
            case (seq_q.phase)
                PH_IDLE: begin
                    if (cmp_low) begin
                        seq_d.phase = PH_HIGH;
                        seq_d.cnt   = ton_q - ONE;
                    end
                end
                PH_HIGH: begin
                    if (seq_q.cnt == '0) seq_d.phase = PH_DEAD;
                    else                 seq_d.cnt   = seq_q.cnt - ONE;
                end
                PH_DEAD: begin
                    seq_d.phase = PH_LOW;
                    seq_d.cnt   = TOFF_LAST;
                end
                default: begin
                    if (seq_q.cnt == '0) seq_d.phase = PH_IDLE;
                    else                 seq_d.cnt   = seq_q.cnt - ONE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.phase <= PH_IDLE;
            seq_q.cnt   <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    fot_gate_out u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase   (seq_q.phase),
        .allow   (allow),
        .pfet_on (pfet_on),
        .nfet_on (nfet_on)
    );

    AST_NO_FIRE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase == PH_IDLE && !cmp_low) |=> seq_q.phase != PH_HIGH); // R3

    AST_HOLD_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase == PH_HIGH && seq_q.cnt != '0 && allow) |=> seq_q.phase == PH_HIGH); // R2

    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase == PH_LOW && seq_q.cnt != '0 && allow) |=> seq_q.phase == PH_LOW); // R6

    AST_LOW_AFTER_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase == PH_DEAD && allow) |=> seq_q.phase == PH_LOW); // R5

    AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !allow |=> seq_q.phase == PH_IDLE); // R7

endmodule

// File: tb/sim_fot_pfm_ctrl.sv
`timescale 1ns/100ps
module sim_fot_pfm_ctrl;
    localparam int CNT_W = 8;
    localparam int TOFF  = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b0;
    logic             mode_pfm = 1'b0;
    logic             cmp_low = 1'b0;
    logic             ton_wr = 1'b0;
    logic [CNT_W-1:0] ton_wdata = '0;
    logic             pfet_on, nfet_on;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc = 0;
    string cur_req = "R1";

    // behavioural reference: pulse age since start
    bit m_busy = 0;
    int m_age = 0;
    int m_lat = 0;
    int m_ton = 16;

    always #2.5 clk = ~clk;

    fot_pfm_ctrl #(.CNT_W(CNT_W), .TSW_CYCLES(20), .TOFF_CYCLES(TOFF)) u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .mode_pfm(mode_pfm),
        .cmp_low(cmp_low), .ton_wr(ton_wr), .ton_wdata(ton_wdata),
        .pfet_on(pfet_on), .nfet_on(nfet_on)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy = 0; m_age = 0; m_lat = 0; m_ton = 16;
        end else begin
            if (!(en && mode_pfm)) begin
                m_busy = 0;
            end else if (m_busy) begin
                m_age++;
                if (m_age > m_lat + TOFF) m_busy = 0;
            end else if (cmp_low) begin
                m_busy = 1; m_age = 0; m_lat = m_ton;
            end
            if (ton_wr) m_ton = (ton_wdata == 0) ? 1 : int'(ton_wdata);
        end
    end

    always @(negedge clk) begin
        bit ok;
        bit ep, en_exp;
        cyc++;
        ok    = en && mode_pfm && rst_n;
        ep    = ok && m_busy && (m_age < m_lat);
        en_exp = ok && m_busy && (m_age > m_lat);
        n_cmp++;
        if (pfet_on !== ep || nfet_on !== en_exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d: pfet/nfet actual %b%b expected %b%b",
                     cur_req, cyc, pfet_on, nfet_on, ep, en_exp);
        end
        n_cmp++;
        if (pfet_on === 1'b1 && nfet_on === 1'b1) begin
            n_bad++;
            $display("FAIL R4 cycle %0d: both on, actual 11 expected not 11", cyc);
        end
    end

    task automatic drive(input bit c, input bit e, input bit m, input bit w,
                         input int wd, input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            cmp_low = c; en = e; mode_pfm = m; ton_wr = w; ton_wdata = CNT_W'(wd);
            if (w) begin
                @(posedge clk); #1; ton_wr = 1'b0;
            end
        end
    endtask

    initial begin
        cur_req = "R1";
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        drive(0, 1, 1, 0, 0, 3);
        cur_req = "R2";                       // default 16-clock pulse, R1
        drive(1, 1, 1, 0, 0, 1);
        drive(0, 1, 1, 0, 0, 25);
        cur_req = "R3";
        drive(0, 1, 1, 0, 0, 30);
        cur_req = "R6";                       // comparator held low, R5 spacing
        drive(1, 1, 1, 0, 0, 70);
        drive(0, 1, 1, 0, 0, 25);
        cur_req = "R8";
        drive(0, 1, 1, 1, 5, 1);
        drive(1, 1, 1, 0, 0, 1);
        drive(0, 1, 1, 1, 0, 1);              // write 0 while pulse runs
        drive(0, 1, 1, 0, 0, 15);
        drive(1, 1, 1, 0, 0, 1);
        drive(0, 1, 1, 0, 0, 10);
        cur_req = "R9";
        @(posedge clk); #1;
        cmp_low = 1; ton_wr = 1; ton_wdata = 8'd3;
        @(posedge clk); #1;
        cmp_low = 0; ton_wr = 0;
        drive(0, 1, 1, 0, 0, 10);
        drive(1, 1, 1, 0, 0, 1);
        drive(0, 1, 1, 0, 0, 12);
        cur_req = "R7";
        drive(0, 1, 1, 1, 12, 1);
        drive(1, 1, 1, 0, 0, 1);
        drive(0, 1, 1, 0, 0, 4);
        drive(0, 0, 1, 0, 0, 6);              // enable drop mid pulse
        drive(1, 1, 0, 0, 0, 20);             // PWM mode selected
        drive(1, 0, 1, 0, 0, 10);
        drive(1, 1, 1, 0, 0, 40);
        drive(0, 1, 1, 0, 0, 25);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #20000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run not finished, actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule